// File: doc/BRIEF.md
# Instruction Address Breakpoint Interrupt Unit

This unit watches the start address of each instruction as it enters the decode stage and compares it with a small set of programmable breakpoint addresses. When an armed breakpoint equals the start address, the unit raises a one-cycle interrupt request, together with the index of the breakpoint that hit. The request comes out before that instruction runs. The request is non-maskable. The unit has no interrupt-enable or priority-level input, so nothing in the core's flag state can hold it back.

Comparison takes place only on the cycle that presents an instruction start. Operand and data fetches never reach the comparators. A breakpoint set to a byte inside an instruction therefore never fires. A stalled decode stage may show the same instruction for several cycles, and that instruction is reported only once. Software loads a breakpoint through a simple write port that sets the address and its arm bit together. The new value is used from the next instruction start onward.

Top module: `addr_match_brk`

## Requirements
- R1: While reset is asserted, and right after it is released, `brkReq` is 0 and `brkIdx` is 0. Every breakpoint is disarmed.
- R2: A first presentation (`instStart`=1 with no held presentation in the previous cycle) whose `instAddr` equals an armed breakpoint gives `brkReq`=1 in the next cycle. `brkIdx` then holds that breakpoint's index.
- R3: A breakpoint whose arm bit is 0 never produces a request, even when its address equals `instAddr`.
- R4: No request is produced for a cycle with `instStart`=0, whatever `instAddr` holds. A breakpoint set to a non-start byte therefore never fires.
- R5: When several armed breakpoints match the same presentation, `brkIdx` reports the lowest index.
- R6: A cycle with `instStart`=1 and `instHold`=1 marks the next cycle's presentation as the same instruction. That repeat presentation produces no request. A later presentation that does not follow a held cycle is compared again.
- R7: A write (`cfgWr`=1) stores `cfgAddr` and `cfgArm` into breakpoint `cfgSel` at the clock edge. A presentation in the same cycle as the write is compared against the old contents, and the next presentation is compared against the new contents.
- R8: `brkReq` lasts exactly one cycle for each reported presentation. `brkIdx` is 0 whenever `brkReq` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| instStart | input | 1 | Decode stage holds an instruction start this cycle |
| instHold | input | 1 | Decode stage stalls; the same instruction is shown again next cycle |
| instAddr | input | ADDR_W (20) | Start address of the presented instruction |
| cfgWr | input | 1 | Breakpoint write strobe |
| cfgSel | input | SEL_W (1) | Index of the breakpoint to write |
| cfgAddr | input | ADDR_W (20) | Breakpoint address to store |
| cfgArm | input | 1 | Arm bit to store |
| brkReq | output | 1 | Non-maskable breakpoint interrupt request, one cycle |
| brkIdx | output | SEL_W (1) | Index of the reporting breakpoint |

## Verification
Each breakpoint's stored address and arm bit can be seen only through later requests. A corrupted address or arm bit therefore shows up at the ports one cycle after the first presentation of the affected address, as a missing, spurious or misattributed request. The bench loads every arm combination and presents each breakpoint address, a shared address and an unrelated address, so a bad register copy is exposed within a few presentations. A wrong stall-tracking bit shows up as a doubled or a lost request on the cycle after a held presentation. The held-then-new sequences are built to catch both cases.

// File: rtl/addr_match_brk_pkg.sv
package addr_match_brk_pkg;

  // Strobes from control to datapath
  typedef struct packed {
    logic cmpEn;   // first presentation of an instruction start
    logic cfgLoad; // load the selected breakpoint entry
  } brkCtl_t;

endpackage

// File: rtl/addr_match_brk_ctrl.sv
module addr_match_brk_ctrl
  import addr_match_brk_pkg::*;
(
  input  logic    clk,
  input  logic    rstN,
  input  logic    instStart,
  input  logic    instHold,
  input  logic    cfgWr,
  output brkCtl_t ctl
);

  // Set when the previous cycle held the same instruction in decode
  logic repeatPres;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      repeatPres <= 1'b0;
    end else begin
      repeatPres <= instStart & instHold;
    end
  end

  always_comb begin
    ctl         = '0;
    ctl.cmpEn   = instStart & ~repeatPres;
    ctl.cfgLoad = cfgWr;
  end

endmodule

// File: rtl/addr_match_brk_dp.sv
module addr_match_brk_dp
  import addr_match_brk_pkg::*;
#(
  parameter int ADDR_W = 20,
  parameter int NUM_BRK = 2,
  localparam int SEL_W = (NUM_BRK > 1) ? $clog2(NUM_BRK) : 1
) (
  input  logic              clk,
  input  logic              rstN,
  input  brkCtl_t           ctl,
  input  logic [ADDR_W-1:0] instAddr,
  input  logic [SEL_W-1:0]  cfgSel,
  input  logic [ADDR_W-1:0] cfgAddr,
  input  logic              cfgArm,
  output logic              brkReq,
  output logic [SEL_W-1:0]  brkIdx
);

  logic [NUM_BRK-1:0] hitVec;
  logic [SEL_W-1:0]   hitSel;
  logic               anyHit;

  for (genvar g = 0; g < NUM_BRK; g++) begin : gen_entry
    logic [ADDR_W-1:0] bpAddr;
    logic              bpArm;
    logic              selMe;

    assign selMe = ctl.cfgLoad && (cfgSel == SEL_W'(g));

    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) begin
        bpAddr <= '0;
        bpArm  <= 1'b0;
      end else if (selMe) begin
        bpAddr <= cfgAddr;
        bpArm  <= cfgArm;
      end
    end

    assign hitVec[g] = bpArm && (bpAddr == instAddr);
  end

  // Lowest index wins
  always_comb begin
    hitSel = '0;
    for (int i = NUM_BRK - 1; i >= 0; i--) begin
      if (hitVec[i]) hitSel = SEL_W'(i);
    end
  end

  assign anyHit = ctl.cmpEn && (|hitVec);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      brkReq <= 1'b0;
      brkIdx <= '0;
    end else begin
      brkReq <= anyHit;
      brkIdx <= anyHit ? hitSel : '0;
    end
  end

endmodule

// File: rtl/addr_match_brk.sv
module addr_match_brk
  import addr_match_brk_pkg::*;
#(
  parameter int ADDR_W = 20,
  parameter int NUM_BRK = 2,
  localparam int SEL_W = (NUM_BRK > 1) ? $clog2(NUM_BRK) : 1
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              instStart,
  input  logic              instHold,
  input  logic [ADDR_W-1:0] instAddr,
  input  logic              cfgWr,
  input  logic [SEL_W-1:0]  cfgSel,
  input  logic [ADDR_W-1:0] cfgAddr,
  input  logic              cfgArm,
  output logic              brkReq,
  output logic [SEL_W-1:0]  brkIdx
);

  brkCtl_t ctl;

  addr_match_brk_ctrl ctrl_i (
    .clk       (clk),
    .rstN      (rstN),
    .instStart (instStart),
    .instHold  (instHold),
    .cfgWr     (cfgWr),
    .ctl       (ctl)
  );

  addr_match_brk_dp #(
    .ADDR_W  (ADDR_W),
    .NUM_BRK (NUM_BRK)
  ) dp_i (
    .clk      (clk),
    .rstN     (rstN),
    .ctl      (ctl),
    .instAddr (instAddr),
    .cfgSel   (cfgSel),
    .cfgAddr  (cfgAddr),
    .cfgArm   (cfgArm),
    .brkReq   (brkReq),
    .brkIdx   (brkIdx)
  );

endmodule

// File: rtl/addr_match_brk_chk.sv
module addr_match_brk_chk #(
  parameter int NUM_BRK = 2,
  parameter int SEL_W = 1
) (
  input logic             clk,
  input logic             rstN,
  input logic             instStart,
  input logic             instHold,
  input logic             brkReq,
  input logic [SEL_W-1:0] brkIdx
);

  always @(posedge clk) begin
    if (!rstN) begin
      AST_QUIET_IN_RESET: assert (!brkReq && brkIdx == '0); // R1
    end
  end

  AST_REQ_NEEDS_START: assert property (@(posedge clk) disable iff (!rstN)
    brkReq |-> $past(instStart)); // R4

  AST_NO_REPEAT_ON_STALL: assert property (@(posedge clk) disable iff (!rstN)
    (instStart && instHold) ##1 instStart |=> !brkReq); // R6

  AST_IDX_ZERO_IDLE: assert property (@(posedge clk) disable iff (!rstN)
    !brkReq |-> brkIdx == '0); // R8

  AST_IDX_IN_RANGE: assert property (@(posedge clk) disable iff (!rstN)
    brkReq |-> (int'(brkIdx) < NUM_BRK)); // R2

endmodule

bind addr_match_brk addr_match_brk_chk #(
  .NUM_BRK (NUM_BRK),
  .SEL_W   (SEL_W)
) chk_i (
  .clk       (clk),
  .rstN      (rstN),
  .instStart (instStart),
  .instHold  (instHold),
  .brkReq    (brkReq),
  .brkIdx    (brkIdx)
);

// File: tb/addr_match_brk_tb_top.sv
module addr_match_brk_tb_top;

  localparam int ADDR_W = 20;
  localparam int NUM_BRK = 2;
  localparam int SEL_W = 1;

  logic              clk = 1'b0;
  logic              rstN = 1'b0;
  logic              instStart = 1'b0;
  logic              instHold = 1'b0;
  logic [ADDR_W-1:0] instAddr = '0;
  logic              cfgWr = 1'b0;
  logic [SEL_W-1:0]  cfgSel = '0;
  logic [ADDR_W-1:0] cfgAddr = '0;
  logic              cfgArm = 1'b0;
  logic              brkReq;
  logic [SEL_W-1:0]  brkIdx;

  int nChecks = 0;
  int nFails = 0;
  bit finished = 1'b0;

  // Bench copy of what has been written (from R7)
  logic [ADDR_W-1:0] mAddr [NUM_BRK];
  logic              mArm  [NUM_BRK];

  always #2 clk = ~clk;

  addr_match_brk #(.ADDR_W(ADDR_W), .NUM_BRK(NUM_BRK)) dut_i (
    .clk(clk), .rstN(rstN), .instStart(instStart), .instHold(instHold),
    .instAddr(instAddr), .cfgWr(cfgWr), .cfgSel(cfgSel), .cfgAddr(cfgAddr),
    .cfgArm(cfgArm), .brkReq(brkReq), .brkIdx(brkIdx)
  );

  task automatic check(string req, int act, int exp);
    nChecks++;
    if (act != exp) begin
      nFails++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic checkOut(string req, bit expReq, int expIdx);
    check({req, " req"}, int'(brkReq), int'(expReq));
    check({req, " idx"}, int'(brkIdx), expIdx);
  endtask

  // Single-cycle write, no presentation
  task automatic writeBp(int sel, logic [ADDR_W-1:0] a, bit arm);
    cfgWr = 1'b1; cfgSel = SEL_W'(sel); cfgAddr = a; cfgArm = arm;
    @(negedge clk);
    cfgWr = 1'b0;
    mAddr[sel] = a; mArm[sel] = arm;
  endtask

  function automatic int expHit(logic [ADDR_W-1:0] a, output int idx);
    idx = 0;
    for (int i = NUM_BRK - 1; i >= 0; i--) begin
      if (mArm[i] && mAddr[i] == a) idx = i;
    end
    for (int i = 0; i < NUM_BRK; i++) begin
      if (mArm[i] && mAddr[i] == a) return 1;
    end
    return 0;
  endfunction

  // One first presentation, then check outputs after the next edge
  task automatic present(string req, logic [ADDR_W-1:0] a);
    int idx;
    int hit;
    hit = expHit(a, idx);
    instStart = 1'b1; instHold = 1'b0; instAddr = a;
    @(negedge clk);
    instStart = 1'b0;
    checkOut(req, hit != 0, hit != 0 ? idx : 0);
  endtask

  localparam logic [ADDR_W-1:0] A0 = 20'h1_2340;
  localparam logic [ADDR_W-1:0] A1 = 20'hF_00A5;
  localparam logic [ADDR_W-1:0] AX = 20'h0_7777;

  initial begin
    for (int i = 0; i < NUM_BRK; i++) begin mAddr[i] = '0; mArm[i] = 1'b0; end
    repeat (3) @(negedge clk);
    checkOut("R1 in reset", 1'b0, 0);
    rstN = 1'b1;
    @(negedge clk);
    checkOut("R1 after reset", 1'b0, 0);
    // R1: disarmed after reset, even address 0 does not hit
    present("R1 disarmed", '0);

    // R2 R3 R5: sweep arm combinations and address patterns
    for (int arms = 0; arms < 4; arms++) begin
      for (int shared = 0; shared < 2; shared++) begin
        writeBp(0, A0, arms[0]);
        writeBp(1, shared != 0 ? A0 : A1, arms[1]);
        present("R2/R3/R5 A0", A0);
        present("R2/R3 A1", A1);
        present("R3 other", AX);
        checkOut("R8 single pulse", 1'b0, 0);
      end
    end

    // R4: address matches but no start strobe
    writeBp(0, A0, 1'b1);
    writeBp(1, A1, 1'b1);
    instStart = 1'b0; instAddr = A0;
    @(negedge clk);
    checkOut("R4 no strobe A0", 1'b0, 0);
    instAddr = A1;
    @(negedge clk);
    checkOut("R4 no strobe A1", 1'b0, 0);
    // R4: non-start byte A0+1 never presented as start, but next start is
    instAddr = A0 + 1;
    @(negedge clk);
    checkOut("R4 operand byte", 1'b0, 0);
    present("R4 real start", A0);

    // R6: held presentation for 3 cycles reports once
    instStart = 1'b1; instHold = 1'b1; instAddr = A1;
    @(negedge clk);
    checkOut("R6 first", 1'b1, 1);
    @(negedge clk);
    checkOut("R6 stall1", 1'b0, 0);
    instHold = 1'b0;
    @(negedge clk);
    checkOut("R6 stall2", 1'b0, 0);
    // new presentation of same address fires again
    @(negedge clk);
    checkOut("R6 new exec", 1'b1, 1);
    instStart = 1'b0;
    @(negedge clk);
    checkOut("R8 idle", 1'b0, 0);
    // back-to-back new presentations both fire
    instStart = 1'b1; instAddr = A0;
    @(negedge clk);
    checkOut("R6 b2b 1", 1'b1, 0);
    @(negedge clk);
    instStart = 1'b0;
    checkOut("R6 b2b 2", 1'b1, 0);

    // R7: write disarm in same cycle as presentation uses old contents
    instStart = 1'b1; instAddr = A0;
    cfgWr = 1'b1; cfgSel = 1'b0; cfgAddr = A0; cfgArm = 1'b0;
    @(negedge clk);
    cfgWr = 1'b0; instStart = 1'b0; mArm[0] = 1'b0;
    checkOut("R7 old armed", 1'b1, 0);
    present("R7 new disarmed", A0);
    // R7: arm in same cycle as presentation -> no hit, next one hits
    instStart = 1'b1; instAddr = AX;
    cfgWr = 1'b1; cfgSel = 1'b1; cfgAddr = AX; cfgArm = 1'b1;
    @(negedge clk);
    cfgWr = 1'b0; instStart = 1'b0; mAddr[1] = AX; mArm[1] = 1'b1;
    checkOut("R7 old unarmed", 1'b0, 0);
    present("R7 new armed", AX);
    present("R7 old addr gone", A1);

    finished = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFails);
    $finish;
  end

  initial begin
    #(200000 * 4);
    if (!finished) begin
      nChecks++;
      nFails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFails);
      $finish;
    end
  end

endmodule